// File: doc/BRIEF.md
# Add/Subtract Unit with Status Flags

This block is the integer add/subtract slice of a 16-bit processor datapath. Each cycle it takes a destination operand, a source operand and a 3-bit operation code. It produces a result at once through combinational logic. Beside the result it computes six status flags. A flag register captures those flags when the execute strobe is high. The stored carry is fed back as the carry-in or borrow-in for the next chained operation.

A byte-mode input narrows the operation to the low eight bits of the operands. In that mode every flag is taken from the 8-bit result, and the upper result byte is forced to zero. Seven operations are supported: plain and carry-chained addition, plain and borrow-chained subtraction, increment, decrement and two's-complement negation. The spare opcode behaves as plain addition.

Top module: `addsub_unit`

## Requirements
- R1: opSel 0 gives dest + src, opSel 1 gives dest + src + stored carry, and opSel 7 behaves exactly as opSel 0. For these opcodes the new carry flag is the unsigned carry out of the operand's top bit.
- R2: opSel 2 gives dest + 1 and opSel 5 gives dest − 1. Both leave the stored carry flag unchanged.
- R3: opSel 3 gives dest − src and opSel 4 gives dest − src − stored carry. For these opcodes the new carry flag is 1 exactly when an unsigned borrow occurs.
- R4: opSel 6 gives 0 − dest. Its carry flag is 1 exactly when the operand is nonzero.
- R5: flagsOut is {overflow, sign, zero, aux, parity, carry}, with carry at bit 0. Aux holds the carry out of bit 3 for additions and the borrow out of bit 3 for subtractions, decrement and negate.
- R6: zero is 1 when the result is all zeros. Sign is the result's top bit. Parity is 1 when result bits 7:0 hold an even number of ones.
- R7: overflow is 1 exactly when the true signed result lies outside the signed range of the operand width.
- R8: with byteMode = 1, only operand bits 7:0 take part, result bits 15:8 are zero, and carry, sign and overflow refer to bit 7.
- R9: the flag register loads the newly computed flags on a rising clock edge where execEn is 1. It holds its value when execEn is 0.
- R10: a low rstN, sampled on a rising clock edge, clears all six flags. Reset takes priority over execEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| execEn | input | 1 | Execute strobe; loads the flag register |
| opSel | input | 3 | Operation code (see R1 to R4) |
| byteMode | input | 1 | 1 selects 8-bit operation, 0 selects 16-bit |
| destIn | input | 16 | Destination operand |
| srcIn | input | 16 | Source operand |
| resultOut | output | 16 | Combinational result |
| flagsOut | output | 6 | Registered flags {overflow, sign, zero, aux, parity, carry} |

## Verification
Directed operands sit on the boundaries where the flags split apart. Adding one to 0x7FFF and to 0xFFFF separates signed overflow from unsigned carry. Negating 0, 0x0001 and 0x8000 covers the three negate cases. Chained add-with-carry and subtract-with-borrow pairs show that the stored carry, and not some other signal, feeds the next operation. Byte-mode cases with nonzero upper bytes prove that the high half is ignored. A long random run then mixes all opcodes, both widths and idle cycles, so that flag holding and increment/decrement carry retention are tested against a behavioural integer model.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  localparam int FLAG_W = 6;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_ADC   = 3'd1,
    OP_INC   = 3'd2,
    OP_SUB   = 3'd3,
    OP_SBB   = 3'd4,
    OP_DEC   = 3'd5,
    OP_NEG   = 3'd6,
    OP_SPARE = 3'd7
  } op_e;

  // second adder operand source
  typedef enum logic [1:0] {
    B_SRC  = 2'd0,
    B_DEST = 2'd1,
    B_NONE = 2'd2
  } bsel_e;

  // adder carry-in source
  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_CF   = 2'd2,
    CIN_NCF  = 2'd3
  } cin_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  zeroA;
    bsel_e bSel;
    logic  invB;
    cin_e  cinSel;
    logic  subMode;
    logic  keepCarry;
  } strobe_t;

  typedef struct packed {
    logic overflow;
    logic sign;
    logic zero;
    logic aux;
    logic parity;
    logic carry;
  } flags_t;

endpackage

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_pkg::*;
(
  input  logic [2:0] opSel,
  output strobe_t    strobes
);

  op_e opCode;
  assign opCode = op_e'(opSel);

  always_comb begin
    strobes = '{zeroA: 1'b0, bSel: B_SRC, invB: 1'b0, cinSel: CIN_ZERO,
                subMode: 1'b0, keepCarry: 1'b0};
    unique case (opCode)
      OP_ADD, OP_SPARE: ;
      OP_ADC: strobes.cinSel = CIN_CF;
      OP_INC: begin
        strobes.bSel      = B_NONE;
        strobes.cinSel    = CIN_ONE;
        strobes.keepCarry = 1'b1;
      end
      OP_SUB: begin
        strobes.invB    = 1'b1;
        strobes.cinSel  = CIN_ONE;
        strobes.subMode = 1'b1;
      end
      OP_SBB: begin
        strobes.invB    = 1'b1;
        strobes.cinSel  = CIN_NCF;
        strobes.subMode = 1'b1;
      end
      OP_DEC: begin
        strobes.bSel      = B_NONE;
        strobes.invB      = 1'b1;
        strobes.subMode   = 1'b1;
        strobes.keepCarry = 1'b1;
      end
      OP_NEG: begin
        strobes.zeroA   = 1'b1;
        strobes.bSel    = B_DEST;
        strobes.invB    = 1'b1;
        strobes.cinSel  = CIN_ONE;
        strobes.subMode = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/addsub_datapath.sv
module addsub_datapath
  import addsub_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  strobe_t            strobes,
  input  logic               byteMode,
  input  logic               carryIn,
  input  logic [DATA_W-1:0]  destIn,
  input  logic [DATA_W-1:0]  srcIn,
  output logic [DATA_W-1:0]  resultOut,
  output flags_t             nextFlags
);

  localparam int HALF_W  = DATA_W / 2;
  localparam int SUM_W   = DATA_W + 1;
  localparam int NIB_POS = 4;
  localparam int PAR_W   = 8;

  logic [DATA_W-1:0] opMask;
  logic [DATA_W-1:0] aOp;
  logic [DATA_W-1:0] bRaw;
  logic [DATA_W-1:0] bOp;
  logic              cin;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  carryVec;
  logic              carryOutRaw;
  logic              carryIntoMsb;
  logic              signBit;

  assign opMask = byteMode ? {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}} : '1;

  always_comb begin
    unique case (strobes.bSel)
      B_SRC:   bRaw = srcIn;
      B_DEST:  bRaw = destIn;
      default: bRaw = '0;
    endcase
  end

  always_comb begin
    unique case (strobes.cinSel)
      CIN_ZERO: cin = 1'b0;
      CIN_ONE:  cin = 1'b1;
      CIN_CF:   cin = carryIn;
      CIN_NCF:  cin = ~carryIn;
    endcase
  end

  assign aOp = (strobes.zeroA ? '0 : destIn) & opMask;
  assign bOp = (strobes.invB ? ~bRaw : bRaw) & opMask;

  // single carry chain; subtraction runs as a + ~b + cin
  assign sum      = {1'b0, aOp} + {1'b0, bOp} + SUM_W'(cin);
  assign carryVec = sum ^ {1'b0, aOp} ^ {1'b0, bOp};

  assign carryOutRaw  = byteMode ? carryVec[HALF_W]   : carryVec[DATA_W];
  assign carryIntoMsb = byteMode ? carryVec[HALF_W-1] : carryVec[DATA_W-1];
  assign signBit      = byteMode ? sum[HALF_W-1]      : sum[DATA_W-1];

  assign resultOut = sum[DATA_W-1:0] & opMask;

  always_comb begin
    nextFlags.carry    = strobes.keepCarry ? carryIn : (carryOutRaw ^ strobes.subMode);
    nextFlags.aux      = carryVec[NIB_POS] ^ strobes.subMode;
    nextFlags.parity   = ~^resultOut[PAR_W-1:0];
    nextFlags.zero     = (resultOut == '0);
    nextFlags.sign     = signBit;
    nextFlags.overflow = carryOutRaw ^ carryIntoMsb;
  end

endmodule

// File: rtl/addsub_flagreg.sv
module addsub_flagreg
  import addsub_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   loadEn,
  input  flags_t nextFlags,
  output flags_t flagsQ
);

  always_ff @(posedge clk) begin
    if (!rstN)       flagsQ <= '0;
    else if (loadEn) flagsQ <= nextFlags;
  end

endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              execEn,
  input  logic [2:0]        opSel,
  input  logic              byteMode,
  input  logic [DATA_W-1:0] destIn,
  input  logic [DATA_W-1:0] srcIn,
  output logic [DATA_W-1:0] resultOut,
  output logic [FLAG_W-1:0] flagsOut
);

  strobe_t strobes;
  flags_t  nextFlags;
  flags_t  flagsQ;

  addsub_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  addsub_datapath #(.DATA_W(DATA_W)) u_dp (
    .strobes   (strobes),
    .byteMode  (byteMode),
    .carryIn   (flagsQ.carry),
    .destIn    (destIn),
    .srcIn     (srcIn),
    .resultOut (resultOut),
    .nextFlags (nextFlags)
  );

  addsub_flagreg u_flags (
    .clk       (clk),
    .rstN      (rstN),
    .loadEn    (execEn),
    .nextFlags (nextFlags),
    .flagsQ    (flagsQ)
  );

  assign flagsOut = flagsQ;

endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              execEn,
  input logic [2:0]        opSel,
  input logic              byteMode,
  input logic [DATA_W-1:0] destIn,
  input logic [DATA_W-1:0] resultOut,
  input logic [5:0]        flagsOut,
  input logic [5:0]        nextFlags
);

  assert_reset_clear_R10: assert property (@(posedge clk)
    !rstN |=> flagsOut == 6'd0);

  assert_flag_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    execEn |=> flagsOut == $past(nextFlags));

  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !execEn |=> $stable(flagsOut));

  assert_keep_carry_R2: assert property (@(posedge clk) disable iff (!rstN)
    (execEn && (opSel == 3'd2 || opSel == 3'd5)) |=> flagsOut[0] == $past(flagsOut[0]));

  assert_neg_carry_R4: assert property (@(posedge clk) disable iff (!rstN)
    (execEn && opSel == 3'd6 && !byteMode) |=> flagsOut[0] == ($past(destIn) != '0));

  assert_byte_upper_R8: assert property (@(posedge clk) disable iff (!rstN)
    byteMode |-> resultOut[DATA_W-1:DATA_W/2] == '0);

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    execEn |=> flagsOut[3] == ($past(resultOut) == '0));

  assert_parity_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    execEn |=> flagsOut[1] == ~^$past(resultOut[7:0]));

endmodule

bind addsub_unit addsub_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .execEn    (execEn),
  .opSel     (opSel),
  .byteMode  (byteMode),
  .destIn    (destIn),
  .resultOut (resultOut),
  .flagsOut  (flagsOut),
  .nextFlags (nextFlags)
);

// File: tb/addsub_unit_bench.sv
module addsub_unit_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN = 1'b0;
  logic        execEn = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic        byteMode = 1'b0;
  logic [15:0] destIn = 16'd0;
  logic [15:0] srcIn = 16'd0;
  logic [15:0] resultOut;
  logic [5:0]  flagsOut;

  int checks = 0;
  int fails = 0;
  logic [5:0] modelFlags = 6'd0;

  addsub_unit u_addsub_unit (
    .clk(clk), .rstN(rstN), .execEn(execEn), .opSel(opSel), .byteMode(byteMode),
    .destIn(destIn), .srcIn(srcIn), .resultOut(resultOut), .flagsOut(flagsOut)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic string opTag(int op);
    case (op)
      2, 5:    return "R2";
      3, 4:    return "R3";
      6:       return "R4";
      default: return "R1";
    endcase
  endfunction

  // behavioural model: returns {flags[5:0], result[15:0]}
  function automatic logic [21:0] model(int op, int d, int s, bit bm, bit cfIn);
    int w, mask, half, a, b, c, full, res, sa, sb, sres;
    bit isSub, keep, cfN, afN, ofN, zfN, sfN, pfN;
    logic [7:0] lowByte;
    w = bm ? 8 : 16;
    mask = (1 << w) - 1;
    half = 1 << (w - 1);
    a = d & mask; b = s & mask; c = 0; isSub = 0; keep = 0;
    case (op)
      1: c = cfIn;
      2: begin b = 1; keep = 1; end
      3: isSub = 1;
      4: begin isSub = 1; c = cfIn; end
      5: begin isSub = 1; b = 1; keep = 1; end
      6: begin isSub = 1; b = d & mask; a = 0; end
      default: ;
    endcase
    sa = (a >= half) ? a - (1 << w) : a;
    sb = (b >= half) ? b - (1 << w) : b;
    if (isSub) begin
      full = a - b - c;
      cfN  = full < 0;
      afN  = ((a & 15) - (b & 15) - c) < 0;
      sres = sa - sb - c;
    end else begin
      full = a + b + c;
      cfN  = ((full >> w) & 1) != 0;
      afN  = ((a & 15) + (b & 15) + c) > 15;
      sres = sa + sb + c;
    end
    ofN = (sres >= half) || (sres < -half);
    res = full & mask;
    zfN = (res == 0);
    sfN = ((res >> (w - 1)) & 1) != 0;
    lowByte = res[7:0];
    pfN = ~^lowByte;
    if (keep) cfN = cfIn;
    return {ofN, sfN, zfN, afN, pfN, cfN, res[15:0]};
  endfunction

  task automatic step(int op, int d, int s, bit bm, bit ex);
    logic [21:0] m;
    @(negedge clk);
    opSel = op[2:0]; destIn = d[15:0]; srcIn = s[15:0]; byteMode = bm; execEn = ex;
    m = model(op, d, s, bm, modelFlags[0]);
    #1;
    check(bm ? "R8" : opTag(op), "result", int'(resultOut), int'(m[15:0]));
    @(posedge clk);
    #1;
    if (ex) begin
      modelFlags = m[21:16];
      check(opTag(op), "carry", int'(flagsOut[0]), int'(modelFlags[0]));
      check("R5", "aux", int'(flagsOut[2]), int'(modelFlags[2]));
      check("R6", "parity", int'(flagsOut[1]), int'(modelFlags[1]));
      check("R6", "zero", int'(flagsOut[3]), int'(modelFlags[3]));
      check("R6", "sign", int'(flagsOut[4]), int'(modelFlags[4]));
      check("R7", "overflow", int'(flagsOut[5]), int'(modelFlags[5]));
    end else begin
      check("R9", "held flags", int'(flagsOut), int'(modelFlags));
    end
  endtask

  task automatic pulseReset();
    @(negedge clk);
    rstN = 1'b0; execEn = 1'b1; opSel = 3'd0; destIn = 16'hFFFF; srcIn = 16'h0001;
    @(posedge clk);
    #1;
    modelFlags = 6'd0;
    check("R10", "flags in reset", int'(flagsOut), 0);
    @(negedge clk);
    rstN = 1'b1; execEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10", "flags after reset", int'(flagsOut), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R1: plain add, carry out, chained add
    step(0, 'h1234, 'h1234, 0, 1);
    step(0, 'hFFFF, 'h0001, 0, 1);
    step(1, 'h0010, 'h0020, 0, 1);
    step(1, 'h7FFF, 'h0000, 0, 1);
    step(7, 'h8000, 'h8000, 0, 1);
    // R2: carry retention on inc/dec
    step(0, 'hFFFF, 'h0001, 0, 1);
    step(2, 'h7FFF, 0, 0, 1);
    step(2, 'hFFFF, 0, 0, 1);
    step(5, 'h8000, 0, 0, 1);
    step(5, 'h0000, 0, 0, 1);
    // R3: borrow and chained subtract
    step(3, 'h0005, 'h0007, 0, 1);
    step(4, 'h0010, 'h0001, 0, 1);
    step(4, 'h8000, 'h7FFF, 0, 1);
    step(3, 'h1234, 'h1234, 0, 1);
    // R4: negate corners
    step(6, 'h0000, 0, 0, 1);
    step(6, 'h0001, 0, 0, 1);
    step(6, 'h8000, 0, 0, 1);
    // R8: byte mode with junk in the upper bytes
    step(0, 'hAB7F, 'hCD01, 1, 1);
    step(0, 'h12FF, 'h3401, 1, 1);
    step(3, 'hFF00, 'h0001, 1, 1);
    step(6, 'h5580, 0, 1, 1);
    // R9: idle cycles keep the flags
    step(0, 'hFFFF, 'hFFFF, 0, 0);
    step(6, 'h0001, 0, 1, 0);
    // R10: reset over a pending execute
    pulseReset();
    step(1, 'h0001, 'h0001, 0, 1);

    for (int i = 0; i < 1500; i++) begin
      int d, s;
      d = ($urandom_range(0, 3) == 0) ? (($urandom_range(0, 1) == 1) ? 'h7FFF : 'h8000)
                                      : int'($urandom_range(0, 65535));
      s = int'($urandom_range(0, 65535));
      step(int'($urandom_range(0, 7)), d, s, $urandom_range(0, 3) == 0,
           $urandom_range(0, 4) != 0);
      if (i == 700) pulseReset();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule